// File: doc/BRIEF.md
# Serial EEPROM Bit-Bang Port Register

This block is a small control register through which host software drives a three-wire serial EEPROM by hand, toggling chip select, serial clock and serial data one write at a time. While the port is switched on and no automatic EEPROM load is running, three stored register bits appear directly on the EEPROM chip-select, clock and data-in pins. Software produces each clock edge by writing the register again. The level on the EEPROM data-out pin can be read back through the same register.

The three pin outputs are shared with other logic. When the port is switched off and no automatic load is active, chip select is held low, the clock pin carries an LED indication, and the data-in pin carries a link-status indication. While an automatic load runs, the load sequencer's own signals own all three pins, whatever the register holds. The register can only be changed while the device is stopped or suspended. Writes at any other time are dropped. A hard reset clears everything. A soft reset clears only the clock and data bits.

The load sequencer and the LED and link logic are outside this block. Their signals enter as plain inputs.

Top module: `eeprom_bitbang_port`

## Requirements
- R1: After a hard reset (`hrst_n` low, then high for two clock edges), every stored bit reads 0 and the pins are in idle mode: `ee_cs`=0, `ee_sk`=`led_in`, `ee_di`=`link_in`.
- R2: A write (`wr_en`=1) is accepted at the rising edge when `stop_st` or `susp_st` is 1. The enable bit is taken from `wr_data[4]`, chip select from `wr_data[2]`, clock from `wr_data[1]` and data-in from `wr_data[0]`.
- R3: A write made while both `stop_st` and `susp_st` are 0 is ignored. All stored bits keep their earlier values.
- R4: With the enable bit 1 and `auto_busy` 0, the pins show the stored bits: `ee_cs`=chip-select bit, `ee_sk`=clock bit, `ee_di`=data-in bit. A new value is visible right after the rising edge that accepts the write.
- R5: With the enable bit 0 and `auto_busy` 0, `ee_cs`=0, `ee_sk` follows `led_in` and `ee_di` follows `link_in`.
- R6: While `auto_busy` is 1, `ee_cs`, `ee_sk` and `ee_di` follow `auto_cs`, `auto_sk` and `auto_di`, whatever the register holds.
- R7: A synchronous soft reset (`srst_n` low at a rising edge) clears the clock and data-in bits and overrides a write to them in the same cycle. It leaves the enable and chip-select bits as they are, and a write to those bits in that cycle still takes effect.
- R8: `rd_data` shows the enable bit at bit 4, chip select at bit 2 and the clock bit at bit 1. Bit 0 shows the live `ee_do` level. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, asynchronous assert, active low |
| srst_n | input | 1 | Soft reset, synchronous, active low |
| stop_st | input | 1 | Device stopped |
| susp_st | input | 1 | Device suspended |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write value |
| rd_data | output | REG_W | Register read value |
| auto_busy | input | 1 | Automatic load in progress |
| auto_cs | input | 1 | Load sequencer chip select |
| auto_sk | input | 1 | Load sequencer serial clock |
| auto_di | input | 1 | Load sequencer serial data |
| led_in | input | 1 | LED indication for the shared clock pin |
| link_in | input | 1 | Link status for the shared data pin |
| ee_do | input | 1 | EEPROM data-out pin |
| ee_cs | output | 1 | EEPROM chip-select pin |
| ee_sk | output | 1 | EEPROM serial clock pin |
| ee_di | output | 1 | EEPROM data-in pin |

## Verification
The pin multiplexer is tested in each of its three ownership states: enabled software drive, idle sharing and automatic load. In each state the stored bits are made to differ from the load sequencer and from the LED and link inputs, so a swapped source shows up as a mismatch. Random writes arrive with every mix of stop and suspend, which separates accepted writes from dropped ones. Soft resets land on the same cycles as writes, which shows that only the clock and data bits are cleared. Directed cases cover the hard-reset state and a hard reset applied in the middle of a run with the port enabled.

// File: rtl/ebb_pkg.sv
package ebb_pkg;
  // register field positions (read and write share them)
  localparam int BIT_DAT = 0;
  localparam int BIT_SK  = 1;
  localparam int BIT_CS  = 2;
  localparam int BIT_EN  = 4;
  // pin lane indices in the pin multiplexer
  localparam int NPIN    = 3;
  localparam int LANE_CS = 0;
  localparam int LANE_SK = 1;
  localparam int LANE_DI = 2;

  typedef struct packed {
    logic en;
    logic cs;
    logic sk;
    logic di;
  } ebb_regs_t;
endpackage

// File: rtl/ebb_rst_sync.sv
module ebb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ebb_ctrl_reg.sv
module ebb_ctrl_reg
  import ebb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      srst_n,
  input  logic      stop_st,
  input  logic      susp_st,
  input  logic      wr_en,
  input  ebb_regs_t wr_val,
  output ebb_regs_t regs_q
);
  ebb_regs_t regs_d;
  logic      wr_ok;
  logic      ld;

  assign wr_ok = wr_en & (stop_st | susp_st);
  assign ld    = wr_ok | ~srst_n;

  always_comb begin
    regs_d = regs_q;
    if (wr_ok) regs_d = wr_val;
    if (!srst_n) begin
      regs_d.sk = 1'b0;
      regs_d.di = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  regs_q <= '0;
    else if (ld) regs_q <= regs_d;
  end
endmodule

// File: rtl/ebb_pin_mux.sv
module ebb_pin_mux
  import ebb_pkg::*;
(
  input  logic            sw_en,
  input  logic            auto_busy,
  input  logic [NPIN-1:0] sw_lane,
  input  logic [NPIN-1:0] auto_lane,
  input  logic [NPIN-1:0] idle_lane,
  output logic [NPIN-1:0] pin_lane
);
  typedef enum logic [1:0] {OWN_IDLE, OWN_SW, OWN_AUTO} owner_e;
  owner_e owner;

  always_comb begin
    if (auto_busy)  owner = OWN_AUTO;
    else if (sw_en) owner = OWN_SW;
    else            owner = OWN_IDLE;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_lane
    always_comb begin
      unique case (owner)
        OWN_AUTO: pin_lane[i] = auto_lane[i];
        OWN_SW:   pin_lane[i] = sw_lane[i];
        default:  pin_lane[i] = idle_lane[i];
      endcase
    end
  end
endmodule

// File: rtl/eeprom_bitbang_port.sv
module eeprom_bitbang_port
  import ebb_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             hrst_n,
  input  logic             srst_n,
  input  logic             stop_st,
  input  logic             susp_st,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             auto_busy,
  input  logic             auto_cs,
  input  logic             auto_sk,
  input  logic             auto_di,
  input  logic             led_in,
  input  logic             link_in,
  input  logic             ee_do,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di
);
  logic            rst_n;
  ebb_regs_t       wr_val;
  ebb_regs_t       regs_q;
  logic [NPIN-1:0] sw_lane, auto_lane, idle_lane, pin_lane;
  logic            unused_rsv;

  ebb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(hrst_n), .rst_n(rst_n)
  );

  assign wr_val.en = wr_data[BIT_EN];
  assign wr_val.cs = wr_data[BIT_CS];
  assign wr_val.sk = wr_data[BIT_SK];
  assign wr_val.di = wr_data[BIT_DAT];
  assign unused_rsv = ^wr_data;

  ebb_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n),
    .stop_st(stop_st), .susp_st(susp_st),
    .wr_en(wr_en), .wr_val(wr_val), .regs_q(regs_q)
  );

  always_comb begin
    sw_lane[LANE_CS]   = regs_q.cs;
    sw_lane[LANE_SK]   = regs_q.sk;
    sw_lane[LANE_DI]   = regs_q.di;
    auto_lane[LANE_CS] = auto_cs;
    auto_lane[LANE_SK] = auto_sk;
    auto_lane[LANE_DI] = auto_di;
    idle_lane[LANE_CS] = 1'b0;
    idle_lane[LANE_SK] = led_in;
    idle_lane[LANE_DI] = link_in;
  end

  ebb_pin_mux u_mux (
    .sw_en(regs_q.en), .auto_busy(auto_busy),
    .sw_lane(sw_lane), .auto_lane(auto_lane), .idle_lane(idle_lane),
    .pin_lane(pin_lane)
  );

  assign ee_cs = pin_lane[LANE_CS];
  assign ee_sk = pin_lane[LANE_SK];
  assign ee_di = pin_lane[LANE_DI];

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_EN]  = regs_q.en;
    rd_data[BIT_CS]  = regs_q.cs;
    rd_data[BIT_SK]  = regs_q.sk;
    rd_data[BIT_DAT] = ee_do;
  end
endmodule

// File: rtl/ebb_chk.sv
module ebb_chk
  import ebb_pkg::*;
#(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             srst_n,
  input logic             stop_st,
  input logic             susp_st,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             auto_busy,
  input logic             auto_cs,
  input logic             auto_sk,
  input logic             auto_di,
  input logic             led_in,
  input logic             link_in,
  input logic             ee_do,
  input logic             ee_cs,
  input logic             ee_sk,
  input logic             ee_di,
  input ebb_regs_t        regs_q
);
  logic [REG_W-1:0] rsv_mask;
  always_comb begin
    rsv_mask          = '1;
    rsv_mask[BIT_EN]  = 1'b0;
    rsv_mask[BIT_CS]  = 1'b0;
    rsv_mask[BIT_SK]  = 1'b0;
    rsv_mask[BIT_DAT] = 1'b0;
  end

  assert_write_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (stop_st || susp_st) && srst_n) |=>
      (rd_data[BIT_EN] == $past(wr_data[BIT_EN]) &&
       rd_data[BIT_CS] == $past(wr_data[BIT_CS]) &&
       rd_data[BIT_SK] == $past(wr_data[BIT_SK])));

  assert_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stop_st && !susp_st && srst_n) |=>
      (rd_data[BIT_EN] == $past(rd_data[BIT_EN]) &&
       rd_data[BIT_CS] == $past(rd_data[BIT_CS]) &&
       rd_data[BIT_SK] == $past(rd_data[BIT_SK])));

  assert_sw_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_q.en && !auto_busy) |->
      (ee_cs == regs_q.cs && ee_sk == regs_q.sk && ee_di == regs_q.di));

  assert_idle_share_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!regs_q.en && !auto_busy) |->
      (!ee_cs && ee_sk == led_in && ee_di == link_in));

  assert_auto_owns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    auto_busy |-> (ee_cs == auto_cs && ee_sk == auto_sk && ee_di == auto_di));

  assert_soft_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_n |=> (!rd_data[BIT_SK] && !regs_q.di));

  assert_soft_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_n && !wr_en) |=> $stable(rd_data[BIT_EN]) && $stable(rd_data[BIT_CS]));

  assert_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[BIT_DAT] == ee_do) && ((rd_data & rsv_mask) == '0));
endmodule

bind eeprom_bitbang_port ebb_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .stop_st(stop_st),
  .susp_st(susp_st), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .auto_busy(auto_busy), .auto_cs(auto_cs), .auto_sk(auto_sk),
  .auto_di(auto_di), .led_in(led_in), .link_in(link_in), .ee_do(ee_do),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .regs_q(regs_q)
);

// File: tb/sim_eeprom_bitbang_port.sv
module sim_eeprom_bitbang_port;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 16;
  localparam int N_RAND = 3000;

  logic clk = 1'b0;
  logic hrst_n, srst_n, stop_st, susp_st, wr_en;
  logic [REG_W-1:0] wr_data, rd_data;
  logic auto_busy, auto_cs, auto_sk, auto_di, led_in, link_in, ee_do;
  logic ee_cs, ee_sk, ee_di;

  int n_chk = 0;
  int n_err = 0;

  // bench model of the stored bits
  logic m_en, m_cs, m_sk, m_di;
  string reg_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_bitbang_port #(.REG_W(REG_W)) u0 (
    .clk(clk), .hrst_n(hrst_n), .srst_n(srst_n), .stop_st(stop_st),
    .susp_st(susp_st), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .auto_busy(auto_busy), .auto_cs(auto_cs), .auto_sk(auto_sk),
    .auto_di(auto_di), .led_in(led_in), .link_in(link_in), .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
  );

  function automatic logic [2:0] exp_pins();
    if (auto_busy) return {auto_cs, auto_sk, auto_di};
    if (m_en)      return {m_cs, m_sk, m_di};
    return {1'b0, led_in, link_in};
  endfunction

  function automatic logic [REG_W-1:0] exp_rd();
    logic [REG_W-1:0] v = '0;
    v[4] = m_en; v[2] = m_cs; v[1] = m_sk; v[0] = ee_do;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [REG_W-1:0] act,
                     input logic [REG_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    string ptag;
    ptag = auto_busy ? "R6" : (m_en ? "R4" : "R5");
    chk(ptag, {13'd0, ee_cs, ee_sk, ee_di}, {13'd0, exp_pins()});
    chk(reg_tag, rd_data, exp_rd());
  endtask

  // inputs already set after a negedge: let the edge happen, update model, check
  task automatic cycle();
    @(posedge clk);
    if (!srst_n) reg_tag = "R7";
    else if (wr_en && (stop_st || susp_st)) reg_tag = "R2";
    else if (wr_en) reg_tag = "R3";
    else reg_tag = "R8";
    if (wr_en && (stop_st || susp_st)) begin
      m_en = wr_data[4]; m_cs = wr_data[2]; m_sk = wr_data[1]; m_di = wr_data[0];
    end
    if (!srst_n) begin m_sk = 1'b0; m_di = 1'b0; end
    @(negedge clk);
    #1;
    check_all();
  endtask

  task automatic quiet();
    srst_n = 1'b1; stop_st = 1'b0; susp_st = 1'b0; wr_en = 1'b0;
    wr_data = '0; auto_busy = 1'b0;
  endtask

  task automatic hard_reset();
    hrst_n = 1'b0;
    m_en = 0; m_cs = 0; m_sk = 0; m_di = 0;
    quiet();
    repeat (2) @(negedge clk);
    hrst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    reg_tag = "R1";
    chk("R1 rd", rd_data, {11'd0, 4'd0, ee_do});
    chk("R1 pins", {13'd0, ee_cs, ee_sk, ee_di}, {13'd0, 1'b0, led_in, link_in});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    auto_cs = 0; auto_sk = 0; auto_di = 0; led_in = 1; link_in = 0; ee_do = 1;
    hard_reset();

    // directed R4: enable with cs=1 sk=0 di=1 while stopped
    @(negedge clk);
    stop_st = 1; wr_en = 1; wr_data = 16'h0015; led_in = 0; link_in = 0;
    cycle();
    // R3: write while running is dropped
    stop_st = 0; wr_en = 1; wr_data = 16'h0002;
    cycle();
    // R6: auto load overrides enabled port
    wr_en = 0; auto_busy = 1; auto_cs = 0; auto_sk = 1; auto_di = 0;
    cycle();
    // R7: soft reset with concurrent write of en/cs under suspend
    auto_busy = 0; susp_st = 1; wr_en = 1; wr_data = 16'h0017; srst_n = 0;
    cycle();
    // R5: disable, idle sharing
    srst_n = 1; wr_data = 16'h0006; led_in = 1; link_in = 1;
    cycle();
    // R8: reserved bits written with ones read as zero
    wr_data = 16'hFFEF; ee_do = 0;
    cycle();

    for (int i = 0; i < N_RAND; i++) begin
      srst_n    = ($urandom_range(15) != 0);
      stop_st   = $urandom_range(1);
      susp_st   = ($urandom_range(3) == 0);
      wr_en     = $urandom_range(1);
      wr_data   = 16'($urandom);
      auto_busy = ($urandom_range(3) == 0);
      auto_cs   = $urandom_range(1);
      auto_sk   = $urandom_range(1);
      auto_di   = $urandom_range(1);
      led_in    = $urandom_range(1);
      link_in   = $urandom_range(1);
      ee_do     = $urandom_range(1);
      cycle();
    end

    // R1: hard reset in the middle of an enabled run
    quiet(); stop_st = 1; wr_en = 1; wr_data = 16'h0017;
    cycle();
    hard_reset();

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule